// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects four interrupt sources for a small 8-bit processor core: two external pins that trigger on a selectable edge, a timer/event counter overflow, and an RC-oscillator converter overflow. The converter overflow is raised by either of two converter timers. Each source has a request flag and an enable bit. These bits sit in two byte-wide control registers, together with one global enable. The core reads and writes the registers through a simple register port.

When the global enable, a source's enable and its flag are all set, and the core's hardware call stack is not full, the block raises a call request with a fixed vector address. The highest-priority eligible source is the one serviced. On the clock edge that ends the call cycle, the serviced flag and the global enable both clear. This stops nesting until software sets the global enable again or the core signals a return-with-interrupt-enable. A plain return leaves the global enable as it is.

Any pending flag drives a wake-up request, whether or not its source is enabled.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, callReq is 0 and wakeReq is 0.
- R2: Register 0 (regAddr=0) holds the following bits, which read back as written. Bit 7 always reads 0.
  - bit0: global enable
  - bit1: external-0 enable
  - bit2: external-1 enable
  - bit3: timer enable
  - bit4: external-0 flag
  - bit5: external-1 flag
  - bit6: timer flag
- R3: Register 1 (regAddr=1) holds two bits: bit0 is the converter enable and bit4 is the converter flag. All other bits read 0.
- R4: With the default parameters, external pin 0 sets its flag on a rising edge and external pin 1 on a falling edge. The opposite edge sets nothing. After a pin changes, the flag reads 1 on the third rising clock edge and not earlier.
- R5: A timerOvf pulse sets the timer flag. A pulse on either rcOvfA or rcOvfB sets the converter flag.
- R6: callReq is 1 only while all four hold: the global enable is 1, a source's enable is 1, that source's flag is 1, and stackFull is 0. The vectors are 0x04 for external 0, 0x08 for external 1, 0x0C for the timer and 0x10 for the converter.
- R7: On the clock edge of a call cycle, the serviced flag and the global enable both clear, so callReq lasts exactly one cycle.
- R8: Flags latch new events while the global enable is 0. These events are held pending and not serviced.
- R9: While stackFull is 1, no call is issued and the request stays pending. The call is issued in the first cycle after stackFull falls.
- R10: A retiPulse sets the global enable. A retPulse leaves it unchanged.
- R11: wakeReq is 1 whenever any request flag is 1, even when that source is disabled.
- R12: When several sources are eligible together, the order is external 0, then external 1, then timer, then converter.
- R13: A hardware event and a CPU write that clears the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin0 | input | 1 | External interrupt pin 0 (asynchronous) |
| extPin1 | input | 1 | External interrupt pin 1 (asynchronous) |
| timerOvf | input | 1 | Timer/event counter overflow pulse |
| rcOvfA | input | 1 | Converter timer A overflow pulse |
| rcOvfB | input | 1 | Converter timer B overflow pulse |
| regAddr | input | 1 | Register select: 0 or 1 |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Selected register contents (combinational) |
| stackFull | input | 1 | Hardware call stack is full |
| retiPulse | input | 1 | Return-with-interrupt-enable executed |
| retPulse | input | 1 | Plain return executed |
| callReq | output | 1 | Call to vector requested this cycle |
| callVector | output | 8 | Vector address of the serviced source |
| wakeReq | output | 1 | Wake-up request: any flag pending |

## Verification
A stuck or stale global enable shows at once: either a second callReq appears in the cycle after a call, or no call follows a retiPulse on the next cycle. A flag that fails to clear on a take appears in the register readback one cycle after the call. It also causes a repeated vector when the enable is restored. A wrong priority or vector mapping is caught by the scoreboard on the very call it affects. A broken edge detector shows as a flag that appears one cycle too early, or on the wrong edge, in the register readback.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int VEC_W   = 8;
  localparam int REG_W   = 8;
  localparam int VEC_STEP = 4;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] takeSel;
  } irqStrobe_t;

  function automatic logic [VEC_W-1:0] vecOf(input int idx);
    return VEC_W'(VEC_STEP * (idx + 1));
  endfunction
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  output logic edgeHit
);
  logic syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pin;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  generate
    if (RISING) begin : g_rise
      assign edgeHit = syncB & ~prevB;
    end else begin : g_fall
      assign edgeHit = ~syncB & prevB;
    end
  endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter bit EXT0_RISING = 1'b1,
  parameter bit EXT1_RISING = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin0,
  input  logic               extPin1,
  input  logic               timerOvf,
  input  logic               rcOvfA,
  input  logic               rcOvfB,
  input  logic               regAddr,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               retiPulse,
  input  irqStrobe_t         strb,
  output logic [REG_W-1:0]   rdData,
  output logic               gie,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_SRC-1:0] srcFlag
);
  logic [NUM_SRC-1:0] hwSet;
  logic [NUM_SRC-1:0] wrHit;
  logic [NUM_SRC-1:0] wrEnBit;
  logic [NUM_SRC-1:0] wrFlagBit;
  logic ext0Edge, ext1Edge;
  logic wr0, wr1;

  irq_edge #(.RISING(EXT0_RISING)) u_edge0 (.clk(clk), .rstN(rstN), .pin(extPin0), .edgeHit(ext0Edge));
  irq_edge #(.RISING(EXT1_RISING)) u_edge1 (.clk(clk), .rstN(rstN), .pin(extPin1), .edgeHit(ext1Edge));

  assign wr0 = wrEn & ~regAddr;
  assign wr1 = wrEn & regAddr;

  assign hwSet     = {rcOvfA | rcOvfB, timerOvf, ext1Edge, ext0Edge};
  assign wrHit     = {wr1, wr0, wr0, wr0};
  assign wrEnBit   = {wrData[0], wrData[3], wrData[2], wrData[1]};
  assign wrFlagBit = {wrData[4], wrData[6], wrData[5], wrData[4]};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          srcEn[i]   <= 1'b0;
          srcFlag[i] <= 1'b0;
        end else begin
          if (wrHit[i]) srcEn[i] <= wrEnBit[i];
          if (hwSet[i])
            srcFlag[i] <= 1'b1;
          else if (strb.take && strb.takeSel[i])
            srcFlag[i] <= 1'b0;
          else if (wrHit[i])
            srcFlag[i] <= wrFlagBit[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gie <= 1'b0;
    else if (strb.take)  gie <= 1'b0;
    else if (retiPulse)  gie <= 1'b1;
    else if (wr0)        gie <= wrData[0];
  end

  always_comb begin
    if (!regAddr)
      rdData = {1'b0, srcFlag[2], srcFlag[1], srcFlag[0], srcEn[2], srcEn[1], srcEn[0], gie};
    else
      rdData = {3'b000, srcFlag[3], 3'b000, srcEn[3]};
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic               gie,
  input  logic               stackFull,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcFlag,
  output irqStrobe_t         strb,
  output logic               callReq,
  output logic [VEC_W-1:0]   callVector
);
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] pick;
  logic               found;

  assign eligible = srcEn & srcFlag & {NUM_SRC{gie & ~stackFull}};

  always_comb begin
    pick       = '0;
    found      = 1'b0;
    callVector = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && !found) begin
        pick[i]    = 1'b1;
        found      = 1'b1;
        callVector = vecOf(i);
      end
    end
  end

  assign callReq      = found;
  assign strb.take    = found;
  assign strb.takeSel = pick;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter bit EXT0_RISING = 1'b1,
  parameter bit EXT1_RISING = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin0,
  input  logic             extPin1,
  input  logic             timerOvf,
  input  logic             rcOvfA,
  input  logic             rcOvfB,
  input  logic             regAddr,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             stackFull,
  input  logic             retiPulse,
  input  logic             retPulse,
  output logic             callReq,
  output logic [VEC_W-1:0] callVector,
  output logic             wakeReq
);
  irqStrobe_t         strb;
  logic               gie;
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] srcFlag;

  irq_regs #(.EXT0_RISING(EXT0_RISING), .EXT1_RISING(EXT1_RISING)) u_regs (
    .clk(clk), .rstN(rstN), .extPin0(extPin0), .extPin1(extPin1),
    .timerOvf(timerOvf), .rcOvfA(rcOvfA), .rcOvfB(rcOvfB),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .retiPulse(retiPulse),
    .strb(strb), .rdData(rdData), .gie(gie), .srcEn(srcEn), .srcFlag(srcFlag)
  );

  irq_ctrl u_ctrl (
    .gie(gie), .stackFull(stackFull), .srcEn(srcEn), .srcFlag(srcFlag),
    .strb(strb), .callReq(callReq), .callVector(callVector)
  );

  assign wakeReq = |srcFlag;
endmodule

// File: rtl/irq_chk.sv
module irq_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             callReq,
  input logic [VEC_W-1:0] callVector,
  input logic             stackFull,
  input logic             wakeReq,
  input logic             retiPulse,
  input logic             retPulse,
  input logic             wrEn,
  input logic             regAddr,
  input logic             gie
);
  // R9: no call while the stack is full
  p_no_call_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !callReq);
  // R6: a call needs the global enable
  p_call_needs_gie_r6: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> gie);
  // R6: only the four vectors can appear
  p_vector_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (callVector == 8'h04 || callVector == 8'h08 ||
                 callVector == 8'h0C || callVector == 8'h10));
  // R7: the call cycle clears the global enable and ends the request
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    callReq |=> (!gie && !callReq));
  // R10: return-with-enable sets the global enable
  p_reti_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !callReq) |=> gie);
  // R10: a plain return leaves the global enable alone
  p_ret_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !retiPulse && !callReq && !(wrEn && !regAddr)) |=> gie == $past(gie));
  // R11: a call implies a pending flag, so wake is up
  p_wake_on_call_r11: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> wakeReq);
endmodule

bind vec_irq_ctrl irq_chk u_irq_chk (
  .clk(clk), .rstN(rstN), .callReq(callReq), .callVector(callVector),
  .stackFull(stackFull), .wakeReq(wakeReq), .retiPulse(retiPulse),
  .retPulse(retPulse), .wrEn(wrEn), .regAddr(regAddr), .gie(gie)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin0 = 0, extPin1 = 0, timerOvf = 0, rcOvfA = 0, rcOvfB = 0;
  logic regAddr = 0, wrEn = 0, stackFull = 0, retiPulse = 0, retPulse = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, callVector;
  logic callReq, wakeReq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .extPin0(extPin0), .extPin1(extPin1),
    .timerOvf(timerOvf), .rcOvfA(rcOvfA), .rcOvfB(rcOvfB),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .stackFull(stackFull), .retiPulse(retiPulse), .retPulse(retPulse),
    .callReq(callReq), .callVector(callVector), .wakeReq(wakeReq)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(logic a, string tag, logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic expectCall(logic [7:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // monitor: every call must match the next expected vector
  always @(negedge clk) begin
    if (rstN && callReq) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected call actual=%h expected=none", callVector);
      end else begin
        string t;
        logic [7:0] e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, callVector, e);
      end
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    rd(0, "R1 reg0 reset", 8'h00);
    rd(1, "R1 reg1 reset", 8'h00);
    check("R1 wake reset", {7'b0, wakeReq}, 8'h00);
    check("R1 call reset", {7'b0, callReq}, 8'h00);

    // R2 / R11 readback with gie off
    wr(0, 8'hFE); rd(0, "R2 reg0 readback", 8'h7E);
    wr(0, 8'h70); rd(0, "R2 flags only", 8'h70);
    check("R11 wake with sources disabled", {7'b0, wakeReq}, 8'h01);
    wr(0, 8'h00); check("R11 wake cleared", {7'b0, wakeReq}, 8'h00);
    // R3
    wr(1, 8'hFF); rd(1, "R3 reg1 readback", 8'h11);
    wr(1, 8'h00); rd(1, "R3 reg1 cleared", 8'h00);

    // R4 rising edge on pin 0
    extPin0 = 1'b1; tick(2); rd(0, "R4 ext0 not before third edge", 8'h00);
    tick(); rd(0, "R4 ext0 rising sets", 8'h10);
    wr(0, 8'h00);
    extPin0 = 1'b0; tick(4); rd(0, "R4 ext0 falling ignored", 8'h00);
    // R4 falling edge on pin 1
    extPin1 = 1'b1; tick(4); rd(0, "R4 ext1 rising ignored", 8'h00);
    extPin1 = 1'b0; tick(3); rd(0, "R4 ext1 falling sets", 8'h20);
    wr(0, 8'h00);

    // R5
    timerOvf = 1; tick(); timerOvf = 0; rd(0, "R5 timer flag", 8'h40);
    wr(0, 8'h00);
    rcOvfA = 1; tick(); rcOvfA = 0; rd(1, "R5 rc via A", 8'h10);
    wr(1, 8'h00);
    rcOvfB = 1; tick(); rcOvfB = 0; rd(1, "R5 rc via B", 8'h10);
    wr(1, 8'h00);

    // R8 pending while gie off
    wr(0, 8'h0E);
    timerOvf = 1; tick(); timerOvf = 0; tick(3);
    rd(0, "R8 pending not serviced", 8'h4E);
    // R6/R7 service timer
    expectCall(8'h0C, "R6 timer vector");
    wr(0, 8'h4F); tick();
    rd(0, "R7 flag and gie cleared", 8'h0E);
    check("R7 call one cycle", {7'b0, callReq}, 8'h00);

    // R12 priority chain with reti
    wr(0, 8'h7E); wr(1, 8'h11);
    expectCall(8'h04, "R12 ext0 first");
    wr(0, 8'h7F); tick();
    rd(0, "R12 ext0 serviced", 8'h6E);
    expectCall(8'h08, "R12 ext1 second");
    retiPulse = 1; tick(); retiPulse = 0; tick();
    rd(0, "R10 reti then ext1 serviced", 8'h4E);
    expectCall(8'h0C, "R12 timer third");
    retiPulse = 1; tick(); retiPulse = 0; tick();
    rd(0, "R12 timer serviced", 8'h0E);
    expectCall(8'h10, "R6 rc vector");
    retiPulse = 1; tick(); retiPulse = 0; tick();
    rd(1, "R12 rc serviced", 8'h01);

    // R10 plain return keeps gie off
    retPulse = 1; tick(); retPulse = 0; tick();
    rd(0, "R10 ret leaves gie", 8'h0E);

    // R9 stack full
    stackFull = 1;
    timerOvf = 1; tick(); timerOvf = 0;
    retiPulse = 1; tick(); retiPulse = 0; tick(3);
    rd(0, "R9 pending while stack full", 8'h4F);
    expectCall(8'h0C, "R9 call after stack frees");
    stackFull = 0; tick();
    rd(0, "R9 serviced after stack frees", 8'h0E);

    // R6 disabled source with gie on
    wr(0, 8'h41); tick(2);
    rd(0, "R6 disabled source not serviced", 8'h41);
    check("R11 wake disabled source", {7'b0, wakeReq}, 8'h01);
    wr(0, 8'h00);

    // R13 hardware set beats write
    regAddr = 0; wrData = 8'h0E; wrEn = 1; timerOvf = 1;
    tick(); wrEn = 0; timerOvf = 0;
    rd(0, "R13 hw set wins", 8'h4E);
    wr(0, 8'h0E); rd(0, "R13 clear afterwards", 8'h0E);

    tick(2);
    check("R6 all expected calls seen", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule